// File: doc/BRIEF.md
# Vectored Line Interrupt Arbiter

This block keeps pending interrupt requests for a group of terminal lines, one bit per line for receive and one bit per line for transmit. Each line raises or drops its own bits through single-cycle set and clear strobes. A line reset strobe drops both of its bits. Each direction drives one master request to the interrupt controller. That request stays high while any line of that direction is still pending.

When the controller acknowledges a direction, the block picks the lowest-numbered pending line of that direction and clears its bit. One cycle later it presents an interrupt vector with a valid flag. The vector is built from a programmable base. Each line owns an 8-byte slot. Receive takes the first word of the slot and transmit takes the word at offset 4. A programmable active-line count hides the upper lines.

The vector output has no back-pressure: `vec_valid` is high for exactly one cycle per acknowledge, and the consumer must take `vec_out` in that cycle. The strobe and acknowledge inputs are plain control pins.

Top module: `line_irq_arbiter`

## Requirements
- R1: While `rst_n` is low, both master requests and `vec_valid` are 0 and every pending bit is cleared.
- R2: A set strobe on an active line makes that line pending from the next edge on. Each master request is the OR of its direction's pending bits, so it stays high until the last pending line of that direction is cleared.
- R3: A clear strobe drops the line's pending bit at the next edge. When a set and a clear hit the same line and direction in the same cycle, the line ends up pending.
- R4: An acknowledge clears only the lowest-numbered pending line of its direction. `vec_valid` is high in exactly the cycle after each acknowledge and low otherwise. A set strobe on the winning line in the acknowledge cycle leaves that line pending.
- R5: A receive vector equals `vec_base + 8*line`, taken modulo 2^VEC_W.
- R6: A transmit vector equals `vec_base + 8*line + 4`, taken modulo 2^VEC_W.
- R7: An acknowledge with nothing pending in its direction returns `vec_valid`=1 with `vec_out`=0 and changes no pending bit.
- R8: A line reset strobe clears both the receive and the transmit bit of that line. It overrides a set strobe in the same cycle.
- R9: Lines whose number is at least the active count read as not pending from the next edge on, and set strobes on them are ignored. A count of 0 acts as 1, and a count above NLINES acts as NLINES.
- R10: When `rx_ack` and `tx_ack` arrive in the same cycle, the receive side is served and the transmit acknowledge is ignored. No transmit bit changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| active_lines | input | $clog2(NLINES+1) | Number of active lines |
| vec_base | input | VEC_W | Vector base |
| rx_set | input | NLINES | Per-line receive request set strobes |
| rx_clr | input | NLINES | Per-line receive request clear strobes |
| tx_set | input | NLINES | Per-line transmit request set strobes |
| tx_clr | input | NLINES | Per-line transmit request clear strobes |
| line_rst | input | NLINES | Per-line reset strobes, clear both directions |
| rx_ack | input | 1 | Receive acknowledge pulse |
| tx_ack | input | 1 | Transmit acknowledge pulse |
| rx_req | output | 1 | Receive master request |
| tx_req | output | 1 | Transmit master request |
| vec_valid | output | 1 | Vector valid, one cycle per acknowledge |
| vec_out | output | VEC_W | Interrupt vector |

## Verification
The pending bits are hidden, and the bench can only see them through the master requests and the acknowledge vectors.

- **Lost bit:** a pending bit dropped by mistake shows up as an early fall of the master request, or as a vector of 0, on the next acknowledge of that direction.
- **Extra bit:** a bit that should have been cleared or masked shows up as a master request that stays high, or as a vector for the wrong line.
- **Wrong arbitration or arithmetic:** a wrong priority order or a wrong slot calculation shows up as a wrong `vec_out` in the cycle right after the acknowledge.

The bench compares every output on every cycle against a behavioural model, so any of these errors is flagged within one cycle of becoming visible.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LINE_STRIDE_LOG2 = 3;  // each line owns an 8-byte vector slot
  localparam int TX_SLOT_OFFSET   = 4;  // transmit vector sits 4 above receive
  localparam int NUM_DIRS         = 2;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } irq_dir_e;
endpackage

// File: rtl/irq_lowest_first.sv
module irq_lowest_first #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  // R4: the chosen line is pending and no lower line is pending
  always_comb begin
    if (found_o === 1'b1) begin
      a_r4_lowest_pick: assert (req_i[idx_o] &&
        ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ack_clr_i,
  input  logic [N-1:0] line_rst_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] pend_o,
  output logic         any_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  // clears first, set overrides them, line reset and mask override everything
  assign pend_d = ((pend_q & ~clr_i & ~ack_clr_i) | set_i) & ~line_rst_i & mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign any_o  = |pend_q;

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & mask_i & ~line_rst_i) != '0) |=>
      ((pend_o & $past(set_i & mask_i & ~line_rst_i)) == $past(set_i & mask_i & ~line_rst_i)));

  a_r2_request_follows_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & mask_i & ~line_rst_i) != '0) |=> any_o);

  a_r8_line_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rst_i != '0) |=> ((pend_o & $past(line_rst_i)) == '0));

  a_r9_inactive_lines_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i != '1) |=> ((pend_o & ~$past(mask_i)) == '0));
endmodule

// File: rtl/line_irq_arbiter.sv
module line_irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int VEC_W  = 9,
  localparam int CNT_W = $clog2(NLINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  active_lines,
  input  logic [VEC_W-1:0]  vec_base,
  input  logic [NLINES-1:0] rx_set,
  input  logic [NLINES-1:0] rx_clr,
  input  logic [NLINES-1:0] tx_set,
  input  logic [NLINES-1:0] tx_clr,
  input  logic [NLINES-1:0] line_rst,
  input  logic              rx_ack,
  input  logic              tx_ack,
  output logic              rx_req,
  output logic              tx_req,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_out
);
  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1;

  // clamp the active count into 1..NLINES and build the line mask
  logic [CNT_W-1:0]  eff_cnt;
  logic [NLINES-1:0] act_mask;

  always_comb begin
    if (active_lines == '0)                  eff_cnt = CNT_W'(1);
    else if (active_lines > CNT_W'(NLINES))  eff_cnt = CNT_W'(NLINES);
    else                                     eff_cnt = active_lines;
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_mask
    assign act_mask[i] = (eff_cnt > CNT_W'(i));
  end

  // per-direction pending banks and arbiters
  logic [NUM_DIRS-1:0][NLINES-1:0] set_v, clr_v, ack_clr_v, pend_v;
  logic [NUM_DIRS-1:0][IDX_W-1:0]  win_idx;
  logic [NUM_DIRS-1:0]             win_found, take, any_v;

  assign set_v[DIR_RX] = rx_set;
  assign set_v[DIR_TX] = tx_set;
  assign clr_v[DIR_RX] = rx_clr;
  assign clr_v[DIR_TX] = tx_clr;
  assign take[DIR_RX]  = rx_ack;
  assign take[DIR_TX]  = tx_ack & ~rx_ack;  // receive served first on a tie

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    irq_pending_bank #(.N(NLINES)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_v[d]),
      .clr_i      (clr_v[d]),
      .ack_clr_i  (ack_clr_v[d]),
      .line_rst_i (line_rst),
      .mask_i     (act_mask),
      .pend_o     (pend_v[d]),
      .any_o      (any_v[d])
    );

    irq_lowest_first #(.N(NLINES)) u_pick (
      .req_i   (pend_v[d]),
      .found_o (win_found[d]),
      .idx_o   (win_idx[d])
    );

    assign ack_clr_v[d] = (take[d] && win_found[d]) ? (NLINES'(1) << win_idx[d]) : '0;
  end

  assign rx_req = any_v[DIR_RX];
  assign tx_req = any_v[DIR_TX];

  // vector formation
  irq_dir_e         srv_dir;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    srv_dir = take[DIR_RX] ? DIR_RX : DIR_TX;
    if (win_found[srv_dir])
      vec_d = vec_base
            + (VEC_W'(win_idx[srv_dir]) << LINE_STRIDE_LOG2)
            + ((srv_dir == DIR_TX) ? VEC_W'(TX_SLOT_OFFSET) : '0);
    else
      vec_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      vec_valid <= |take;
      if (|take) vec_out <= vec_d;
    end
  end

  // R1: outputs quiet during reset
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      a_r1_reset_quiet: assert (!rx_req && !tx_req && !vec_valid);
    end
  end

  a_r4_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack || tx_ack) |=> vec_valid);

  a_r4_valid_only_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ack || tx_ack) |=> !vec_valid);

  a_r7_empty_rx_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && !rx_req) |=> (vec_valid && vec_out == '0));

  a_r10_tx_kept_on_tie: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && tx_ack && tx_req && tx_clr == '0 && line_rst == '0 && act_mask == '1) |=> tx_req);
endmodule

// File: tb/line_irq_arbiter_tb.sv
`timescale 1ns/1ps
module line_irq_arbiter_tb;
  localparam int N  = 16;
  localparam int VW = 9;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] active_lines = CW'(N);
  logic [VW-1:0] vec_base = '0;
  logic [N-1:0]  rx_set = '0, rx_clr = '0, tx_set = '0, tx_clr = '0, line_rst = '0;
  logic          rx_ack = 1'b0, tx_ack = 1'b0;
  logic          rx_req, tx_req, vec_valid;
  logic [VW-1:0] vec_out;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  line_irq_arbiter #(.NLINES(N), .VEC_W(VW)) u_dut (
    .clk(clk), .rst_n(rst_n), .active_lines(active_lines), .vec_base(vec_base),
    .rx_set(rx_set), .rx_clr(rx_clr), .tx_set(tx_set), .tx_clr(tx_clr),
    .line_rst(line_rst), .rx_ack(rx_ack), .tx_ack(tx_ack),
    .rx_req(rx_req), .tx_req(tx_req), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  // behavioural reference model
  bit            m_rx[N];
  bit            m_tx[N];
  bit            e_valid;
  logic [VW-1:0] e_vec;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_rx[i]) begin m_rx[i] = 0; m_tx[i] = 0; end
      e_valid = 0;
      e_vec = '0;
    end else begin
      int eff;
      int win;
      bit dir_tx;
      eff = (active_lines == 0) ? 1 : ((active_lines > N) ? N : int'(active_lines));
      win = -1;
      e_valid = rx_ack || tx_ack;
      dir_tx = !rx_ack && tx_ack;
      if (e_valid) begin
        for (int i = N - 1; i >= 0; i--)
          if (dir_tx ? m_tx[i] : m_rx[i]) win = i;
        if (win < 0) e_vec = '0;
        else e_vec = VW'(int'(vec_base) + win * 8 + (dir_tx ? 4 : 0));
      end
      for (int i = 0; i < N; i++) begin
        if (rx_clr[i] || (e_valid && !dir_tx && win == i)) m_rx[i] = 0;
        if (tx_clr[i] || (e_valid && dir_tx && win == i))  m_tx[i] = 0;
        if (rx_set[i]) m_rx[i] = 1;
        if (tx_set[i]) m_tx[i] = 1;
        if (line_rst[i] || i >= eff) begin m_rx[i] = 0; m_tx[i] = 0; end
      end
    end
  end

  function automatic bit any_of(input bit v[N]);
    any_of = 0;
    foreach (v[i]) if (v[i]) any_of = 1;
  endfunction

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act %0h exp %0h", tag, what, act, exp);
    end
  endtask

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("rx_req", 16'(rx_req), 16'(any_of(m_rx)));
      chk("tx_req", 16'(tx_req), 16'(any_of(m_tx)));
      chk("vec_valid", 16'(vec_valid), 16'(e_valid));
      if (e_valid) chk("vec_out", 16'(vec_out), 16'(e_vec));
    end
  end

  task automatic drive(input logic [N-1:0] rs, input logic [N-1:0] rc,
                       input logic [N-1:0] ts, input logic [N-1:0] tc,
                       input logic [N-1:0] lr, input logic ra, input logic ta);
    rx_set = rs; rx_clr = rc; tx_set = ts; tx_clr = tc; line_rst = lr;
    rx_ack = ra; tx_ack = ta;
    @(negedge clk);
    rx_set = '0; rx_clr = '0; tx_set = '0; tx_clr = '0; line_rst = '0;
    rx_ack = 1'b0; tx_ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    tag = "R1";
    repeat (3) @(negedge clk);
    chk("rx_req in reset", 16'(rx_req), 16'h0);
    chk("tx_req in reset", 16'(tx_req), 16'h0);
    chk("vec_valid in reset", 16'(vec_valid), 16'h0);
    rst_n = 1'b1;
    idle(2);

    // R2: set lines 3 and 5, request stays up until both served
    tag = "R2";
    drive(16'h0028, '0, '0, '0, '0, 0, 0);
    idle(1);
    tag = "R5";
    vec_base = 9'h100;
    drive('0, '0, '0, '0, '0, 1, 0);  // line 3 -> 0x118
    drive('0, '0, '0, '0, '0, 1, 0);  // line 5 -> 0x128
    tag = "R7";
    drive('0, '0, '0, '0, '0, 1, 0);  // nothing pending -> 0
    drive('0, '0, '0, '0, '0, 0, 1);
    idle(1);

    // R6: transmit vectors, including modulo wrap
    tag = "R6";
    vec_base = 9'h1F0;
    drive('0, '0, 16'h8001, '0, '0, 0, 0);
    drive('0, '0, '0, '0, '0, 0, 1);  // line 0 -> 0x1F4
    drive('0, '0, '0, '0, '0, 0, 1);  // line 15 -> 0x06C
    idle(1);

    // R3: set and clear together, then clear alone
    tag = "R3";
    vec_base = 9'h040;
    drive(16'h0004, 16'h0004, 16'h0004, 16'h0004, '0, 0, 0);
    idle(1);
    drive('0, 16'h0004, '0, '0, '0, 0, 0);
    drive('0, '0, '0, 16'h0004, '0, 0, 0);
    idle(1);

    // R8: line reset clears both directions and beats a set
    tag = "R8";
    drive(16'h0002, '0, 16'h0002, '0, '0, 0, 0);
    drive(16'h0002, '0, 16'h0002, '0, 16'h0002, 0, 0);
    idle(1);
    drive('0, '0, '0, '0, '0, 1, 0);
    drive('0, '0, '0, '0, '0, 0, 1);

    // R4: set on the winning line in the ack cycle keeps it pending
    tag = "R4";
    drive(16'h0240, '0, '0, '0, '0, 0, 0);
    drive(16'h0040, '0, '0, '0, '0, 1, 0);
    drive('0, '0, '0, '0, '0, 1, 0);
    drive('0, '0, '0, '0, '0, 1, 0);
    drive('0, '0, '0, '0, '0, 1, 0);

    // R10: simultaneous acknowledges
    tag = "R10";
    drive(16'h0010, '0, 16'h0004, '0, '0, 0, 0);
    drive('0, '0, '0, '0, '0, 1, 1);
    drive('0, '0, '0, '0, '0, 0, 1);
    idle(1);

    // R9: active line count and clamping
    tag = "R9";
    active_lines = CW'(4);
    drive(16'h0088, '0, 16'h0080, '0, '0, 0, 0);
    drive('0, '0, '0, '0, '0, 1, 0);
    drive('0, '0, '0, '0, '0, 0, 1);
    drive(16'h000C, '0, '0, '0, '0, 0, 0);
    active_lines = CW'(2);
    idle(2);
    drive('0, '0, '0, '0, '0, 1, 0);
    active_lines = CW'(0);
    drive(16'h0003, '0, '0, '0, '0, 0, 0);
    drive('0, '0, '0, '0, '0, 1, 0);
    drive('0, '0, '0, '0, '0, 1, 0);
    active_lines = CW'(20);
    drive(16'h8000, '0, '0, '0, '0, 0, 0);
    drive('0, '0, '0, '0, '0, 1, 0);
    active_lines = CW'(N);
    idle(1);

    // mixed random traffic
    tag = "R4";
    for (int k = 0; k < 600; k++) begin
      if ($urandom_range(0, 40) == 0) active_lines = CW'($urandom_range(0, 20));
      if ($urandom_range(0, 30) == 0) vec_base = VW'($urandom);
      drive(N'($urandom & $urandom), N'($urandom & $urandom & $urandom),
            N'($urandom & $urandom), N'($urandom & $urandom & $urandom),
            ($urandom_range(0, 6) == 0) ? N'($urandom & $urandom) : '0,
            ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0));
    end
    idle(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule